// File: doc/BRIEF.md
# Parametric Receive Focusing Delay and Apodization Generator

This block produces the receive-focusing sample instants for a single ultrasound channel while an echo line is being received. It keeps no delay table. When a line begins, it loads five values. Three of them set the delay curve: a starting delay, a starting step and a change of step. Two of them set the aperture: the point index at which the channel switches on and the index at which it switches off. From then on a sample counter runs. Each time the counter reaches the integer part of the current delay, the block emits a capture strobe and advances the delay by a second-order adder recurrence.

The delay curve follows only from the parameter values, so linear array focusing and phased array steering use the same logic. Both the delay and the step are two's-complement fixed point with a fractional part, which keeps the focusing error below one clock over the whole line. The apodization output is a binary enable for the current output point. After the last output point the block raises a done flag. The next line-start pulse clears it.

Top module: `focus_delay_gen`

## Requirements
- R1: After reset, capStrobe is 0, lineDone is 0, pointIdx is 0 and apodWeight is 0.
- R2: On a clock edge where lineStart is 1, all five parameters are captured, pointIdx is cleared to 0, lineDone is cleared and the sample counter restarts. The counter reads 0 in the first cycle after that edge and increases by one every cycle after it.
- R3: The first strobe of a line occurs in the cycle where the sample counter equals the integer part of initDelay. The integer part is bits [INT_W+FRAC_W-1:FRAC_W], and the low FRAC_W bits are the fraction.
- R4: After each strobe the delay gains the current step, and the step then gains secondDiff. Both adds are two's-complement with FRAC_W fraction bits. Strobe k therefore follows floor(D_k), where D_0 = initDelay, S_0 = initIncr, D_k+1 = D_k + S_k and S_k+1 = S_k + secondDiff.
- R5: A strobe is issued whenever the sample counter is at or past the integer part of the current delay. When a delay falls at or behind the previous strobe, its strobe comes in the next cycle. Strobe k therefore lands at max(floor(D_k), t_k-1 + 1).
- R6: pointIdx equals k while strobe k is asserted. It advances by one after each strobe and holds otherwise.
- R7: apodWeight is 1 exactly when apodOn <= pointIdx < apodOff, using unsigned compares. An apodOn that is not below apodOff keeps the weight at 0 for the whole line.
- R8: Exactly POINTS strobes are issued per line. lineDone rises in the cycle after the last strobe and stays high until the next lineStart, and no strobe occurs while it is high.
- R9: A lineStart in the middle of a line abandons the remaining points and starts the new line under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle pulse that loads the parameters and starts a line |
| initDelay | input | INT_W+FRAC_W | Starting delay in clocks, unsigned fixed point |
| initIncr | input | INT_W+FRAC_W | Starting per-point delay step, signed fixed point |
| secondDiff | input | INT_W+FRAC_W | Per-point change of the step, signed fixed point |
| apodOn | input | $clog2(POINTS)+1 | First point index with the channel enabled |
| apodOff | input | $clog2(POINTS)+1 | First point index with the channel disabled again |
| capStrobe | output | 1 | Capture the current sample for the current point |
| pointIdx | output | $clog2(POINTS) | Index of the current output point |
| apodWeight | output | 1 | Aperture enable for the current point |
| lineDone | output | 1 | All points of the line have been issued |

## Verification
A wrong value in the delay or step register shows up at the first strobe after the error, as a shifted strobe time. The recurrence adds the error again at every later point, so the shift grows and a per-strobe time comparison catches it at once. A wrong point counter appears as a pointIdx that disagrees with the strobe count, or as a lineDone that comes early or late, at the latest by the end of the line. Aperture errors appear as apodWeight mismatches at the boundary points. Each set of parameters is replayed against an independent model of the recurrence, including a curve whose delay falls back and a curve whose step is below one clock.

// File: rtl/fdg_pkg.sv
package fdg_pkg;
  // Strobes from the sequencer to the delay datapath and aperture logic
  typedef struct packed {
    logic load;   // capture line parameters
    logic step;   // advance to the next output point
  } fdgCtrl_t;
endpackage

// File: rtl/fdg_ctrl.sv
module fdg_ctrl
  import fdg_pkg::*;
#(
  parameter int POINTS = 512,
  parameter int INT_W  = 16,
  localparam int PIW   = $clog2(POINTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [INT_W-1:0] delayInt,
  output fdgCtrl_t         ctrl,
  output logic             capStrobe,
  output logic [PIW-1:0]   pointIdx,
  output logic             lineDone
);
  localparam logic [PIW-1:0]   LAST_PT = PIW'(POINTS - 1);
  localparam logic [INT_W-1:0] CNT_MAX = {INT_W{1'b1}};

  logic             active;
  logic             doneQ;
  logic [INT_W-1:0] sampleCnt;
  logic [PIW-1:0]   pointCnt;
  logic             hit;

  // Catch-up compare: fires at or after the integer delay
  assign hit       = active && (sampleCnt >= delayInt);
  assign capStrobe = hit;
  assign pointIdx  = pointCnt;
  assign lineDone  = doneQ;

  always_comb begin
    ctrl      = '0;
    ctrl.load = lineStart;
    ctrl.step = hit && !lineStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      doneQ     <= 1'b0;
      sampleCnt <= '0;
      pointCnt  <= '0;
    end else if (lineStart) begin
      active    <= 1'b1;
      doneQ     <= 1'b0;
      sampleCnt <= '0;
      pointCnt  <= '0;
    end else begin
      if (active && sampleCnt != CNT_MAX) sampleCnt <= sampleCnt + 1'b1;
      if (hit) begin
        if (pointCnt == LAST_PT) begin
          active <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          pointCnt <= pointCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdg_delay.sv
module fdg_delay
  import fdg_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8,
  localparam int DW    = INT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  fdgCtrl_t         ctrl,
  input  logic [DW-1:0]    initDelay,
  input  logic [DW-1:0]    initIncr,
  input  logic [DW-1:0]    secondDiff,
  output logic [INT_W-1:0] delayInt
);
  logic [DW-1:0] delayQ;
  logic [DW-1:0] incrQ;
  logic [DW-1:0] diffQ;

  assign delayInt = delayQ[DW-1:FRAC_W];

  // Second-order recurrence; two's-complement wrap makes signed steps work
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayQ <= '0;
      incrQ  <= '0;
      diffQ  <= '0;
    end else if (ctrl.load) begin
      delayQ <= initDelay;
      incrQ  <= initIncr;
      diffQ  <= secondDiff;
    end else if (ctrl.step) begin
      delayQ <= delayQ + incrQ;
      incrQ  <= incrQ + diffQ;
    end
  end
endmodule

// File: rtl/fdg_apod.sv
module fdg_apod
  import fdg_pkg::*;
#(
  parameter int POINTS = 512,
  localparam int PIW   = $clog2(POINTS),
  localparam int AW    = PIW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  fdgCtrl_t       ctrl,
  input  logic [AW-1:0]  apodOn,
  input  logic [AW-1:0]  apodOff,
  input  logic [PIW-1:0] pointIdx,
  output logic           weight
);
  logic [AW-1:0] onQ;
  logic [AW-1:0] offQ;
  logic [AW-1:0] idxExt;

  assign idxExt = {1'b0, pointIdx};
  assign weight = (idxExt >= onQ) && (idxExt < offQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onQ  <= '0;
      offQ <= '0;
    end else if (ctrl.load) begin
      onQ  <= apodOn;
      offQ <= apodOff;
    end
  end
endmodule

// File: rtl/focus_delay_gen.sv
module focus_delay_gen
  import fdg_pkg::*;
#(
  parameter int POINTS = 512,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8,
  localparam int DW    = INT_W + FRAC_W,
  localparam int PIW   = $clog2(POINTS),
  localparam int AW    = PIW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           lineStart,
  input  logic [DW-1:0]  initDelay,
  input  logic [DW-1:0]  initIncr,
  input  logic [DW-1:0]  secondDiff,
  input  logic [AW-1:0]  apodOn,
  input  logic [AW-1:0]  apodOff,
  output logic           capStrobe,
  output logic [PIW-1:0] pointIdx,
  output logic           apodWeight,
  output logic           lineDone
);
  fdgCtrl_t         ctrl;
  logic [INT_W-1:0] delayInt;

  fdg_ctrl #(.POINTS(POINTS), .INT_W(INT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .delayInt(delayInt),
    .ctrl(ctrl), .capStrobe(capStrobe), .pointIdx(pointIdx), .lineDone(lineDone)
  );

  fdg_delay #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_delay (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .initDelay(initDelay),
    .initIncr(initIncr), .secondDiff(secondDiff), .delayInt(delayInt)
  );

  fdg_apod #(.POINTS(POINTS)) u_apod (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .apodOn(apodOn), .apodOff(apodOff),
    .pointIdx(pointIdx), .weight(apodWeight)
  );
endmodule

// File: rtl/fdg_checker.sv
module fdg_checker #(
  parameter int POINTS = 512,
  localparam int PIW   = $clog2(POINTS)
) (
  input logic           clk,
  input logic           rstN,
  input logic           lineStart,
  input logic           capStrobe,
  input logic [PIW-1:0] pointIdx,
  input logic           lineDone
);
  localparam logic [PIW-1:0] LAST_PT = PIW'(POINTS - 1);

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (pointIdx == '0) && !lineDone);  // R2

  AST_POINT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (capStrobe && !lineStart && pointIdx != LAST_PT) |=> pointIdx == $past(pointIdx) + 1'b1);  // R6

  AST_POINT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!capStrobe && !lineStart) |=> $stable(pointIdx));  // R6

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (capStrobe && !lineStart && pointIdx == LAST_PT) |=> lineDone);  // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lineDone && !lineStart) |=> lineDone);  // R8

  AST_NO_STROBE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> !capStrobe);  // R8
endmodule

bind focus_delay_gen fdg_checker #(.POINTS(POINTS)) u_fdgChecker (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .capStrobe(capStrobe),
  .pointIdx(pointIdx), .lineDone(lineDone)
);

// File: tb/focus_delay_gen_bench.sv
module focus_delay_gen_bench;
  localparam int POINTS = 512;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 8;
  localparam int DW     = INT_W + FRAC_W;
  localparam int PIW    = $clog2(POINTS);
  localparam int AW     = PIW + 1;

  typedef struct {
    int t;
    int idx;
    bit w;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           lineStart = 1'b0;
  logic [DW-1:0]  initDelay = '0;
  logic [DW-1:0]  initIncr = '0;
  logic [DW-1:0]  secondDiff = '0;
  logic [AW-1:0]  apodOn = '0;
  logic [AW-1:0]  apodOff = '0;
  logic           capStrobe;
  logic [PIW-1:0] pointIdx;
  logic           apodWeight;
  logic           lineDone;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit expectDone = 0;
  bit finished = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  focus_delay_gen u_focus_delay_gen (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .initDelay(initDelay),
    .initIncr(initIncr), .secondDiff(secondDiff), .apodOn(apodOn), .apodOff(apodOff),
    .capStrobe(capStrobe), .pointIdx(pointIdx), .apodWeight(apodWeight), .lineDone(lineDone)
  );

  // Cycle count since the edge that took lineStart; equals the sample counter
  always @(posedge clk) begin
    if (lineStart) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string msg);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: pops expected strobes and compares time, index and weight
  always @(negedge clk) begin
    if (rstN) begin
      if (expectDone) begin
        expectDone = 0;
        check(lineDone === 1'b1 && capStrobe === 1'b0, "R8",
              $sformatf("after last strobe lineDone=%b capStrobe=%b exp 1/0", lineDone, capStrobe));
      end
      if (capStrobe === 1'b1) begin
        if (expQ.size() == 0) begin
          check(0, "R8", $sformatf("unexpected strobe at cycle %0d idx %0d, exp none", cyc, pointIdx));
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(cyc == e.t && int'(pointIdx) == e.idx && apodWeight == e.w, "R4/R5/R6/R7",
                $sformatf("strobe t=%0d idx=%0d w=%b exp t=%0d idx=%0d w=%b",
                          cyc, pointIdx, apodWeight, e.t, e.idx, e.w));
          if (e.idx == POINTS - 1) expectDone = 1;
        end
      end
    end
  end

  // Driver: model the recurrence, queue expected strobes, pulse lineStart
  task automatic runLine(input longint d0, input longint s0, input longint dd,
                         input int on, input int off, input int abortAt, input string tag);
    longint d = d0;
    longint s = s0;
    int prev = -1;
    for (int k = 0; k < POINTS; k++) begin
      expItem_t e;
      int ti;
      ti = int'(d >>> FRAC_W);
      e.t = (ti > prev) ? ti : prev + 1;
      e.idx = k;
      e.w = (k >= on) && (k < off);
      prev = e.t;
      if (abortAt < 0 || e.t <= abortAt) expQ.push_back(e);
      d = d + s;
      s = s + dd;
    end
    @(negedge clk);
    #1;
    initDelay  = DW'(d0);
    initIncr   = DW'(s0);
    secondDiff = DW'(dd);
    apodOn     = AW'(on);
    apodOff    = AW'(off);
    lineStart  = 1'b1;
    @(negedge clk);
    // R2: counter restarted, pointIdx cleared, done cleared
    check(cyc == 0 && pointIdx == '0 && lineDone == 1'b0, "R2",
          $sformatf("%s start cyc=%0d idx=%0d done=%b exp 0/0/0", tag, cyc, pointIdx, lineDone));
    #1;
    lineStart = 1'b0;
    if (abortAt >= 0) begin
      // R9: stop here; the next line's pulse lands at cycle abortAt
      while (cyc != abortAt - 1) @(negedge clk);
    end else begin
      while (lineDone !== 1'b1) @(negedge clk);
      check(expQ.size() == 0, "R8",
            $sformatf("%s strobes missing at done: %0d left, exp 0", tag, expQ.size()));
      repeat (3) @(negedge clk);
      check(lineDone === 1'b1 && capStrobe === 1'b0, "R8",
            $sformatf("%s done hold done=%b strobe=%b exp 1/0", tag, lineDone, capStrobe));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(capStrobe === 1'b0 && lineDone === 1'b0 && pointIdx === '0 && apodWeight === 1'b0, "R1",
          $sformatf("reset strobe=%b done=%b idx=%0d w=%b exp 0/0/0/0",
                    capStrobe, lineDone, pointIdx, apodWeight));
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(capStrobe === 1'b0 && lineDone === 1'b0, "R1",
          $sformatf("idle strobe=%b done=%b exp 0/0", capStrobe, lineDone));
    // R3/R4 linear-array style curve, aperture 10..499
    runLine(20 * 256 + 128, 320, 1, 10, 500, -1, "linear");
    // R9 abort mid-line, then R4/R5 phased curve that turns back, full aperture
    runLine(20 * 256 + 128, 320, 1, 10, 500, 200, "abort");
    runLine(100 * 256, 768, -2, 0, 512, -1, "phased");
    // R5 step below one clock: catch-up strobes; R7 empty aperture
    runLine(3 * 256 + 64, 77, 0, 300, 100, -1, "slow");
    // R3 zero initial delay: strobe in first cycle
    runLine(0, 256, 0, 511, 512, -1, "zero");
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not end, exp completion");
    summary();
  end
endmodule